// File: doc/BRIEF.md
# Interrupt Presentation Controller

This block is the per-processor presentation stage of a two-layer interrupt controller. For each of a small, parameterised number of servers it keeps one pending interrupt and drives one interrupt line toward the processor. The source layer offers deliveries (a source number and a priority). The presentation stage either latches each delivery or hands it back as a reject. Where the protocol calls for it, it also asks the source layer to resend earlier rejects, and it passes end-of-interrupt notices back.

Each server holds a 32-bit accept word and two priority registers. The top 8 bits of the accept word are the current processor priority and the low 24 bits are the pending source number. One register holds the priority of the pending interrupt and the other holds the inter-processor-interrupt (IPI) priority. A lower number means a more favoured priority. The processor side issues one operation per cycle, aimed at one server: set the current priority, set the IPI priority, accept, or end-of-interrupt. Every notification and every accept result appears as a registered single-cycle pulse in the cycle after the event that caused it.

Top module: `intr_present`

## Requirements
- R1: After reset every interrupt line is low, no pulse is driven, the current priority is 0x00, the pending priority and IPI priority are 0xFF, and an accept returns 0x00000000.
- R2: A delivery is turned back with a reject pulse carrying its own number if its priority is not below the current priority, or if a pending interrupt has a priority less than or equal to it.
- R3: A delivery that is not turned back displaces any pending interrupt. The displaced number is sent as a reject, the new number and priority are latched, and the line is high.
- R4: A server's interrupt line is high exactly while its pending source number is nonzero.
- R5: Accept (op_kind 2) pulses acc_valid with {current priority[31:24], pending number[23:0]}. It then clears the number, lowers the line, and loads the current priority from the pending priority.
- R6: End-of-interrupt (op_kind 3) pulses an EOI carrying op_data[23:0] and loads op_data[31:24] into the current priority. If nothing is pending it also performs a resend.
- R7: Set current priority (op_kind 0, value in op_data[7:0]) to a lower value clears a pending interrupt whose priority is at or above the new value, with a reject of its number. Setting a same-or-higher value with nothing pending performs a resend.
- R8: Set IPI priority (op_kind 1, value in op_data[7:0]) stores the value, and if it is below the current priority the IPI check runs. The IPI is presented unless the pending priority is at or below the IPI priority. Presenting it rejects any other pending number and latches source number 2 with the IPI priority.
- R9: A resend pulses rsnd_valid. In the same step, if the IPI priority is below the current priority, it runs the IPI check.
- R10: A delivery to the server that the processor operation targets in the same cycle is applied one cycle later, after that operation. The source layer sends no new delivery to a server while one is held for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Processor operation present |
| op_server | input | SRV_W | Server addressed by the operation |
| op_kind | input | 2 | 0 set current priority, 1 set IPI priority, 2 accept, 3 end-of-interrupt |
| op_data | input | 32 | Operation operand |
| dlv_valid | input | 1 | Delivery from the source layer |
| dlv_server | input | SRV_W | Target server of the delivery |
| dlv_num | input | 24 | Source number of the delivery (nonzero) |
| dlv_prio | input | 8 | Priority of the delivery |
| irq_out | output | NSRV | Interrupt line per server |
| rej_valid | output | NSRV | Reject pulse per server |
| rej_num | output | NSRV x 24 | Rejected source number per server |
| rsnd_valid | output | NSRV | Resend request pulse per server |
| eoi_valid | output | NSRV | End-of-interrupt pulse per server |
| eoi_num | output | NSRV x 24 | Source number retired per server |
| acc_valid | output | 1 | Accept result valid |
| acc_data | output | 32 | Accept word returned |

## Verification
On every cycle the assertions check the port-level consequences that need no knowledge of stored priorities. An accept lowers the line, and the word it returns has a nonzero number exactly when the line was high. An end-of-interrupt echoes its number. A delivery at the worst priority always comes back as a reject of itself. Writing the IPI priority as 0xFF leaves the line untouched. The outcomes that depend on the priorities held in each server can only be shown by the bench's reference model across directed and random sequences. These include displacement order, clearing by a lowered current priority, IPI presentation during a resend, and the one-cycle deferral of a colliding delivery.

// File: rtl/intr_present_pkg.sv
package intr_present_pkg;

    localparam int NUM_W  = 24;
    localparam int PRIO_W = 8;
    localparam int WORD_W = NUM_W + PRIO_W;

    typedef logic [NUM_W-1:0]  src_num_t;
    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [WORD_W-1:0] word_t;

    localparam src_num_t IPI_SRC   = src_num_t'(2);
    localparam prio_t    PRIO_LEAST = '1;

    typedef enum logic [1:0] {
        OP_SET_CUR = 2'd0,
        OP_SET_IPI = 2'd1,
        OP_ACCEPT  = 2'd2,
        OP_EOI     = 2'd3
    } cpu_op_e;

    typedef struct packed {
        prio_t    cur;
        src_num_t num;
        prio_t    pend;
        prio_t    ipi;
    } srv_state_t;

    typedef struct packed {
        logic     rej;
        src_num_t rej_num;
        logic     rsnd;
        logic     eoi;
        src_num_t eoi_num;
        logic     acc;
        word_t    acc_word;
    } srv_note_t;

    typedef struct packed {
        srv_state_t st;
        srv_note_t  nt;
    } srv_pair_t;

    typedef struct packed {
        src_num_t num;
        prio_t    prio;
    } dlv_t;

    localparam srv_state_t STATE_RESET = '{
        cur:  '0,
        num:  '0,
        pend: PRIO_LEAST,
        ipi:  PRIO_LEAST
    };

    // Hand a source number back to the source layer.
    function automatic srv_pair_t f_push_back(srv_pair_t p, src_num_t n);
        srv_pair_t q;
        q            = p;
        q.nt.rej     = 1'b1;
        q.nt.rej_num = n;
        return q;
    endfunction

    // Decide whether the inter-processor interrupt takes the pending slot.
    function automatic srv_pair_t f_try_ipi(srv_pair_t p);
        srv_pair_t q;
        q = p;
        if (!(q.st.num != '0 && q.st.pend <= q.st.ipi)) begin
            if (q.st.num != '0) begin
                q = f_push_back(q, q.st.num);
            end
            q.st.num  = IPI_SRC;
            q.st.pend = q.st.ipi;
        end
        return q;
    endfunction

    function automatic srv_pair_t f_resend(srv_pair_t p);
        srv_pair_t q;
        q = p;
        if (q.st.ipi < q.st.cur) begin
            q = f_try_ipi(q);
        end
        q.nt.rsnd = 1'b1;
        return q;
    endfunction

    function automatic srv_pair_t f_deliver(srv_pair_t p, dlv_t d);
        srv_pair_t q;
        q = p;
        if (d.prio >= q.st.cur || (q.st.num != '0 && q.st.pend <= d.prio)) begin
            q = f_push_back(q, d.num);
        end else begin
            if (q.st.num != '0) begin
                q = f_push_back(q, q.st.num);
            end
            q.st.num  = d.num;
            q.st.pend = d.prio;
        end
        return q;
    endfunction

    function automatic srv_pair_t f_cpu_op(srv_pair_t p, cpu_op_e k, word_t d);
        srv_pair_t q;
        prio_t     newp;
        q    = p;
        newp = d[PRIO_W-1:0];
        case (k)
            OP_SET_CUR: begin
                if (newp < q.st.cur) begin
                    q.st.cur = newp;
                    if (q.st.num != '0 && newp <= q.st.pend) begin
                        q        = f_push_back(q, q.st.num);
                        q.st.num = '0;
                    end
                end else begin
                    q.st.cur = newp;
                    if (q.st.num == '0) begin
                        q = f_resend(q);
                    end
                end
            end
            OP_SET_IPI: begin
                q.st.ipi = newp;
                if (newp < q.st.cur) begin
                    q = f_try_ipi(q);
                end
            end
            OP_ACCEPT: begin
                q.nt.acc      = 1'b1;
                q.nt.acc_word = {q.st.cur, q.st.num};
                q.st.cur      = q.st.pend;
                q.st.num      = '0;
            end
            OP_EOI: begin
                q.nt.eoi     = 1'b1;
                q.nt.eoi_num = d[NUM_W-1:0];
                q.st.cur     = d[WORD_W-1:NUM_W];
                if (q.st.num == '0) begin
                    q = f_resend(q);
                end
            end
            default: ;
        endcase
        return q;
    endfunction

endpackage

// File: rtl/ip_hold_slot.sv
module ip_hold_slot
    import intr_present_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic op_hit,
    input  logic fresh_hit,
    input  dlv_t fresh_dlv,
    output logic go,
    output dlv_t go_dlv
);

    logic slot_v;
    dlv_t slot_d;

    // A held delivery goes first; a colliding fresh one waits a cycle.
    assign go     = !op_hit && (slot_v || fresh_hit);
    assign go_dlv = slot_v ? slot_d : fresh_dlv;

    always_ff @(posedge clk) begin
        if (rst) begin
            slot_v <= 1'b0;
            slot_d <= '0;
        end else if (op_hit) begin
            if (fresh_hit && !slot_v) begin
                slot_v <= 1'b1;
                slot_d <= fresh_dlv;
            end
        end else begin
            slot_v <= 1'b0;
        end
    end

endmodule

// File: rtl/ip_server_core.sv
module ip_server_core
    import intr_present_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      op_hit,
    input  cpu_op_e   op_kind,
    input  word_t     op_data,
    input  logic      dlv_go,
    input  dlv_t      dlv_in,
    output logic      irq,
    output srv_note_t note
);

    srv_state_t state;
    srv_pair_t  nxt;

    always_comb begin
        nxt.st = state;
        nxt.nt = '0;
        if (op_hit) begin
            nxt = f_cpu_op(nxt, op_kind, op_data);
        end else if (dlv_go) begin
            nxt = f_deliver(nxt, dlv_in);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= STATE_RESET;
            note  <= '0;
        end else begin
            state <= nxt.st;
            note  <= nxt.nt;
        end
    end

    assign irq = (state.num != '0);

endmodule

// File: rtl/ip_accept_merge.sv
module ip_accept_merge
    import intr_present_pkg::*;
#(
    parameter int NSRV = 4
) (
    input  logic [NSRV-1:0]             acc_v,
    input  logic [NSRV-1:0][WORD_W-1:0] acc_w,
    output logic                        acc_valid,
    output logic [WORD_W-1:0]           acc_data
);

    always_comb begin
        acc_valid = 1'b0;
        acc_data  = '0;
        for (int i = 0; i < NSRV; i++) begin
            acc_valid = acc_valid | acc_v[i];
            acc_data  = acc_data | (acc_w[i] & {WORD_W{acc_v[i]}});
        end
    end

endmodule

// File: rtl/intr_present.sv
module intr_present
    import intr_present_pkg::*;
#(
    parameter int NSRV = 4,
    localparam int SRV_W = (NSRV > 1) ? $clog2(NSRV) : 1
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        op_valid,
    input  logic [SRV_W-1:0]            op_server,
    input  logic [1:0]                  op_kind,
    input  logic [31:0]                 op_data,
    input  logic                        dlv_valid,
    input  logic [SRV_W-1:0]            dlv_server,
    input  logic [23:0]                 dlv_num,
    input  logic [7:0]                  dlv_prio,
    output logic [NSRV-1:0]             irq_out,
    output logic [NSRV-1:0]             rej_valid,
    output logic [NSRV-1:0][23:0]       rej_num,
    output logic [NSRV-1:0]             rsnd_valid,
    output logic [NSRV-1:0]             eoi_valid,
    output logic [NSRV-1:0][23:0]       eoi_num,
    output logic                        acc_valid,
    output logic [31:0]                 acc_data
);

    dlv_t                        fresh;
    cpu_op_e                     kind;
    logic [NSRV-1:0]             acc_v;
    logic [NSRV-1:0][WORD_W-1:0] acc_w;

    assign fresh = '{num: dlv_num, prio: dlv_prio};
    assign kind  = cpu_op_e'(op_kind);

    for (genvar i = 0; i < NSRV; i++) begin : g_srv
        logic      op_hit;
        logic      fresh_hit;
        logic      go;
        dlv_t      go_dlv;
        srv_note_t note;

        assign op_hit    = op_valid && (op_server == SRV_W'(i));
        assign fresh_hit = dlv_valid && (dlv_server == SRV_W'(i));

        ip_hold_slot u_hold (
            .clk       (clk),
            .rst       (rst),
            .op_hit    (op_hit),
            .fresh_hit (fresh_hit),
            .fresh_dlv (fresh),
            .go        (go),
            .go_dlv    (go_dlv)
        );

        ip_server_core u_core (
            .clk     (clk),
            .rst     (rst),
            .op_hit  (op_hit),
            .op_kind (kind),
            .op_data (op_data),
            .dlv_go  (go),
            .dlv_in  (go_dlv),
            .irq     (irq_out[i]),
            .note    (note)
        );

        assign rej_valid[i]  = note.rej;
        assign rej_num[i]    = note.rej_num;
        assign rsnd_valid[i] = note.rsnd;
        assign eoi_valid[i]  = note.eoi;
        assign eoi_num[i]    = note.eoi_num;
        assign acc_v[i]      = note.acc;
        assign acc_w[i]      = note.acc_word;
    end

    ip_accept_merge #(.NSRV(NSRV)) u_merge (
        .acc_v     (acc_v),
        .acc_w     (acc_w),
        .acc_valid (acc_valid),
        .acc_data  (acc_data)
    );

endmodule

// File: rtl/ip_checker.sv
module ip_checker #(
    parameter int NSRV = 4,
    localparam int SRV_W = (NSRV > 1) ? $clog2(NSRV) : 1
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  op_valid,
    input logic [1:0]            op_kind,
    input logic [SRV_W-1:0]      op_server,
    input logic [23:0]           op_low,
    input logic                  dlv_valid,
    input logic [SRV_W-1:0]      dlv_server,
    input logic [23:0]           dlv_num,
    input logic [7:0]            dlv_prio,
    input logic [NSRV-1:0]       irq_out,
    input logic [NSRV-1:0]       rej_valid,
    input logic [NSRV-1:0][23:0] rej_num,
    input logic [NSRV-1:0]       eoi_valid,
    input logic [NSRV-1:0][23:0] eoi_num,
    input logic                  acc_valid,
    input logic [23:0]           acc_num
);

    for (genvar i = 0; i < NSRV; i++) begin : g_chk
        // R5: accept lowers the line; the returned number mirrors the line
        a_r5_accept_drops_line: assert property (@(posedge clk) disable iff (rst)
            (op_valid && op_kind == 2'd2 && op_server == SRV_W'(i))
            |=> (!irq_out[i] && acc_valid && ((acc_num != 24'd0) == $past(irq_out[i]))));

        // R6: end-of-interrupt echoes its number on the same server
        a_r6_eoi_echo: assert property (@(posedge clk) disable iff (rst)
            (op_valid && op_kind == 2'd3 && op_server == SRV_W'(i))
            |=> (eoi_valid[i] && eoi_num[i] == $past(op_low)));

        // R2: worst priority can never pass the current priority
        a_r2_worst_bounced: assert property (@(posedge clk) disable iff (rst)
            (dlv_valid && dlv_server == SRV_W'(i) && dlv_prio == 8'hFF
             && !(op_valid && op_server == SRV_W'(i)))
            |=> (rej_valid[i] && rej_num[i] == $past(dlv_num)));

        // R8: an IPI priority of 0xFF never presents anything
        a_r8_ipi_off_quiet: assert property (@(posedge clk) disable iff (rst)
            (op_valid && op_kind == 2'd1 && op_server == SRV_W'(i) && op_low[7:0] == 8'hFF)
            |=> $stable(irq_out[i]));
    end

endmodule

bind intr_present ip_checker #(.NSRV(NSRV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_server  (op_server),
    .op_low     (op_data[23:0]),
    .dlv_valid  (dlv_valid),
    .dlv_server (dlv_server),
    .dlv_num    (dlv_num),
    .dlv_prio   (dlv_prio),
    .irq_out    (irq_out),
    .rej_valid  (rej_valid),
    .rej_num    (rej_num),
    .eoi_valid  (eoi_valid),
    .eoi_num    (eoi_num),
    .acc_valid  (acc_valid),
    .acc_num    (acc_data[23:0])
);

// File: tb/sim_intr_present.sv
module sim_intr_present;

    localparam int NS = 4;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             op_valid = 1'b0;
    logic [1:0]       op_server = '0;
    logic [1:0]       op_kind = '0;
    logic [31:0]      op_data = '0;
    logic             dlv_valid = 1'b0;
    logic [1:0]       dlv_server = '0;
    logic [23:0]      dlv_num = '0;
    logic [7:0]       dlv_prio = '0;
    logic [NS-1:0]    irq_out;
    logic [NS-1:0]    rej_valid;
    logic [NS-1:0][23:0] rej_num;
    logic [NS-1:0]    rsnd_valid;
    logic [NS-1:0]    eoi_valid;
    logic [NS-1:0][23:0] eoi_num;
    logic             acc_valid;
    logic [31:0]      acc_data;

    intr_present #(.NSRV(NS)) u0 (.*);

    always #5 clk = ~clk;

    int n_cmp = 0;
    int n_bad = 0;

    // reference model state
    int m_cur[NS], m_num[NS], m_pend[NS], m_ipi[NS];
    bit m_hv[NS];
    int m_hn[NS], m_hp[NS];
    bit e_irq[NS], e_rej[NS], e_rs[NS], e_eoi[NS];
    int e_rejn[NS], e_eoin[NS];
    bit e_acc;
    int e_accd;

    task automatic chk(string tag, string what, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic m_bounce(int s, int n);
        e_rej[s]  = 1'b1;
        e_rejn[s] = n;
    endtask

    task automatic m_ipi_check(int s);
        if (m_num[s] != 0 && m_pend[s] <= m_ipi[s]) return;
        if (m_num[s] != 0) m_bounce(s, m_num[s]);
        m_num[s]  = 2;
        m_pend[s] = m_ipi[s];
    endtask

    task automatic m_resend(int s);
        if (m_ipi[s] < m_cur[s]) m_ipi_check(s);
        e_rs[s] = 1'b1;
    endtask

    task automatic m_deliver(int s, int n, int p);
        if (p >= m_cur[s] || (m_num[s] != 0 && m_pend[s] <= p)) begin
            m_bounce(s, n);
        end else begin
            if (m_num[s] != 0) m_bounce(s, m_num[s]);
            m_num[s]  = n;
            m_pend[s] = p;
        end
    endtask

    task automatic m_op(int s, int k, int d);
        int v;
        v = d & 255;
        case (k)
            0: begin
                if (v < m_cur[s]) begin
                    m_cur[s] = v;
                    if (m_num[s] != 0 && v <= m_pend[s]) begin
                        m_bounce(s, m_num[s]);
                        m_num[s] = 0;
                    end
                end else begin
                    m_cur[s] = v;
                    if (m_num[s] == 0) m_resend(s);
                end
            end
            1: begin
                m_ipi[s] = v;
                if (v < m_cur[s]) m_ipi_check(s);
            end
            2: begin
                e_acc    = 1'b1;
                e_accd   = (m_cur[s] << 24) | m_num[s];
                m_cur[s] = m_pend[s];
                m_num[s] = 0;
            end
            default: begin
                e_eoi[s]  = 1'b1;
                e_eoin[s] = d & 32'h00FF_FFFF;
                m_cur[s]  = (d >> 24) & 255;
                if (m_num[s] == 0) m_resend(s);
            end
        endcase
    endtask

    task automatic m_clear_pulses();
        e_acc = 1'b0;
        e_accd = 0;
        for (int s = 0; s < NS; s++) begin
            e_rej[s] = 0; e_rs[s] = 0; e_eoi[s] = 0;
            e_rejn[s] = 0; e_eoin[s] = 0;
        end
    endtask

    task automatic m_reset();
        for (int s = 0; s < NS; s++) begin
            m_cur[s] = 0; m_num[s] = 0; m_pend[s] = 255; m_ipi[s] = 255;
            m_hv[s] = 0; m_hn[s] = 0; m_hp[s] = 0; e_irq[s] = 0;
        end
        m_clear_pulses();
    endtask

    task automatic m_cycle(bit ov, int os, int ok, int od, bit dv, int ds, int dn, int dp);
        m_clear_pulses();
        for (int s = 0; s < NS; s++) begin
            bit oh, fh;
            oh = ov && (os == s);
            fh = dv && (ds == s);
            if (oh) begin
                m_op(s, ok, od);
                if (fh && !m_hv[s]) begin
                    m_hv[s] = 1; m_hn[s] = dn; m_hp[s] = dp;
                end
            end else if (m_hv[s]) begin
                m_deliver(s, m_hn[s], m_hp[s]);
                m_hv[s] = 0;
            end else if (fh) begin
                m_deliver(s, dn, dp);
            end
            e_irq[s] = (m_num[s] != 0);
        end
    endtask

    task automatic compare(string tag);
        for (int s = 0; s < NS; s++) begin
            chk(tag, $sformatf("irq[%0d]", s), int'(irq_out[s]), int'(e_irq[s]));
            chk(tag, $sformatf("rej[%0d]", s), int'(rej_valid[s]), int'(e_rej[s]));
            if (e_rej[s]) chk(tag, $sformatf("rej_num[%0d]", s), int'(rej_num[s]), e_rejn[s]);
            chk(tag, $sformatf("rsnd[%0d]", s), int'(rsnd_valid[s]), int'(e_rs[s]));
            chk(tag, $sformatf("eoi[%0d]", s), int'(eoi_valid[s]), int'(e_eoi[s]));
            if (e_eoi[s]) chk(tag, $sformatf("eoi_num[%0d]", s), int'(eoi_num[s]), e_eoin[s]);
        end
        chk(tag, "acc_valid", int'(acc_valid), int'(e_acc));
        if (e_acc) chk(tag, "acc_data", int'(acc_data), e_accd);
    endtask

    // Drive at a falling edge, let one rising edge pass, compare at the next falling edge.
    task automatic step(string tag, bit ov, int os, int ok, int od,
                        bit dv, int ds, int dn, int dp);
        op_valid   = ov;
        op_server  = 2'(os);
        op_kind    = 2'(ok);
        op_data    = 32'(od);
        dlv_valid  = dv;
        dlv_server = 2'(ds);
        dlv_num    = 24'(dn);
        dlv_prio   = 8'(dp);
        m_cycle(ov, os, ok, od, dv, ds, dn, dp);
        @(posedge clk);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic op(string tag, int s, int k, int d);
        step(tag, 1, s, k, d, 0, 0, 0, 0);
    endtask

    task automatic dlv(string tag, int s, int n, int p);
        step(tag, 0, 0, 0, 0, 1, s, n, p);
    endtask

    task automatic idle(string tag);
        step(tag, 0, 0, 0, 0, 0, 0, 0, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired before the end of the run");
        summary();
        $finish;
    end

    initial begin
        m_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        compare("R1");                         // reset state
        op("R1", 0, 2, 0);                     // accept after reset returns 0
        // open server 0 fully: EOI with priority 0xFF, nothing pending -> resend
        op("R6", 0, 3, 32'hFF00_0000);
        // R2: favoured delivery latched, then two that lose
        dlv("R2", 0, 32'h20, 5);
        dlv("R2", 0, 32'h21, 7);
        dlv("R2", 0, 32'h22, 5);
        // R3: better priority displaces 0x20
        dlv("R3", 0, 32'h23, 3);
        // R5: accept returns {FF, 23}; current becomes 3
        op("R5", 0, 2, 0);
        dlv("R2", 0, 32'h24, 3);               // equal to current -> rejected
        // R6: EOI restores 0xFF and resends
        op("R6", 0, 3, 32'hFF00_0023);
        // R7: lowering current priority to pending level clears it
        dlv("R7", 0, 32'h30, 6);
        op("R7", 0, 0, 6);
        op("R7", 0, 0, 32'h10);                // raise with nothing pending -> resend
        dlv("R7", 0, 32'h31, 2);
        op("R7", 0, 0, 4);                     // 4 above pending 2 -> kept
        // R8: IPI priority 1 beats pending 2; then 3 does not
        op("R8", 0, 1, 1);
        op("R8", 0, 1, 3);
        op("R8", 1, 1, 32'h80);                // server 1 current 0 -> nothing
        op("R8", 0, 1, 32'hFF);
        op("R8", 0, 1, 3);
        // R9: accept, then EOI resend presents the IPI
        op("R9", 0, 2, 0);
        op("R9", 0, 3, 32'h0500_0002);
        // R10: collision on server 1
        op("R10", 1, 3, 32'hFF00_0000);
        step("R10", 1, 1, 1, 32'hFF, 1, 1, 32'h40, 9);
        idle("R10");
        step("R10", 1, 1, 0, 8, 1, 1, 32'h41, 4);
        idle("R10");
        op("R4", 1, 2, 0);
        // random traffic, all servers
        for (int c = 0; c < 4000; c++) begin
            bit ov, dv;
            int os, ok, od, ds, dn, dp, pr;
            ov = ($urandom % 3) != 0;
            os = $urandom % NS;
            ok = $urandom % 4;
            pr = (($urandom % 8) == 0) ? 255 : ($urandom % 16);
            od = (ok == 3) ? ((pr << 24) | (16 + $urandom % 64)) : pr;
            dv = ($urandom % 2) != 0;
            ds = $urandom % NS;
            if (m_hv[ds]) dv = 0;
            dn = 16 + ($urandom % 200);
            dp = (($urandom % 10) == 0) ? 255 : ($urandom % 16);
            step("R3", ov, os, ok, od, dv, ds, dn, dp);
        end
        idle("R4");
        summary();
        $finish;
    end

endmodule